// File: doc/BRIEF.md
# Configurable Serial Frame Receiver

This block turns an asynchronous serial line into bytes. A clock-enable strobe from an external baud divider paces the sampling. At runtime the block can take 8 or 16 samples per bit. It can also invert the sense of the start and stop levels, take data MSB-first or LSB-first, add and check an even or odd parity bit, and expect one or two stop bits. Each finished byte waits in a single holding register until the consumer takes it through a valid/ready handshake.

Every frame is checked. A parity mismatch, a stop bit at the wrong level, a frame held entirely at the start level (a break), and a frame that finishes while the previous byte is still waiting (an overrun) each produce a one-cycle error pulse. An interrupt line combines these pulses and the byte-available condition. Each source has its own enable, and a global enable gates them all. When flow control is enabled, a request-to-send output reports whether the holding register can accept a byte.

Top module: `serial_rx`

## Requirements
- R1: After reset, rx_valid, all error pulses and irq are 0, and rts_n is 0 (holding register empty).
- R2: With cfg_os16=1 a bit lasts 16 sample_tick strobes; with cfg_os16=0 it lasts 8. A start is confirmed by a sample taken half a bit after the edge is first seen, and each later bit is sampled one full bit after the previous sample.
- R3: With cfg_start_low=1 the start level is 0 and the stop/idle level is 1; with cfg_start_low=0 both levels are swapped. Data and parity bits are taken from the line without inversion.
- R4: With cfg_lsb_first=1 the first data bit received becomes rx_data[0]; with cfg_lsb_first=0 it becomes rx_data[7].
- R5: With cfg_par_en=1 a parity bit follows the 8 data bits. The XOR of the data bits and the parity bit must equal cfg_par_odd (0 = even, 1 = odd), or err_parity pulses with the byte. With cfg_par_en=0 the frame carries no parity bit.
- R6: With cfg_two_stop=1 two stop bits are checked, otherwise one. If any checked stop sample is at the start level, err_frame pulses with the byte, which is still delivered.
- R7: If the confirmation sample is no longer at the start level, the detection is discarded. No byte is delivered and no error is raised.
- R8: If every sample of a frame, stop bits included, is at the start level, err_break pulses, no byte is delivered, and err_frame and err_parity stay 0. The receiver then waits for the line to reach the stop level before it looks for a new start.
- R9: If a frame completes while rx_valid=1 and rx_ready=0, err_overrun pulses, the new byte is dropped and the held byte is kept.
- R10: rx_valid stays 1 and rx_data stays unchanged until a cycle with rx_ready=1. That cycle removes the byte.
- R11: irq (registered, one cycle after its sources) is ie_global AND the OR of (ie_rx AND rx_valid), (ie_break AND err_break), (ie_parity AND err_parity), (ie_frame AND err_frame) and (ie_overrun AND err_overrun).
- R12: rts_oe equals cfg_rts_en. rts_n is 1 while the holding register is full and 0 while it is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_tick | input | 1 | Oversampling clock-enable strobe |
| rxd | input | 1 | Serial line |
| cfg_os16 | input | 1 | 1: 16 samples per bit, 0: 8 |
| cfg_start_low | input | 1 | 1: start low / stop high, 0: swapped |
| cfg_lsb_first | input | 1 | 1: LSB first, 0: MSB first |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even |
| cfg_two_stop | input | 1 | Two stop bits |
| cfg_rts_en | input | 1 | Flow-control output enable |
| ie_global | input | 1 | Global interrupt enable |
| ie_rx | input | 1 | Byte-available interrupt enable |
| ie_break | input | 1 | Break interrupt enable |
| ie_parity | input | 1 | Parity error interrupt enable |
| ie_frame | input | 1 | Framing error interrupt enable |
| ie_overrun | input | 1 | Overrun interrupt enable |
| rx_ready | input | 1 | Consumer takes the held byte |
| rx_data | output | 8 | Held byte |
| rx_valid | output | 1 | Holding register full |
| err_break | output | 1 | Break pulse |
| err_parity | output | 1 | Parity error pulse |
| err_frame | output | 1 | Framing error pulse |
| err_overrun | output | 1 | Overrun pulse |
| irq | output | 1 | Combined interrupt |
| rts_n | output | 1 | 1 = not ready for data |
| rts_oe | output | 1 | Drive enable for rts_n |

## Verification
The bench sweeps every combination of rate, polarity, bit order, parity and stop count with several bytes each. A wrong midpoint or bit period would show up there as shifted or corrupted bytes, and a mishandled order or polarity would show up as reversed or rejected bytes. Directed frames corrupt the parity bit, the first stop bit or only the second stop bit. A receiver that skipped the second stop, or that used the wrong parity sense, would miss a pulse or raise a spurious one. A short glitch must not produce a byte. A full-frame break must raise only the break pulse and must not re-trigger while the line is held. A second frame with no read in between must leave the first byte in place. A slower strobe rate and the interrupt and request-to-send gating complete the set.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_WAIT
    } rx_state_e;
endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd,
    output logic line
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d = q;
        d.sh = {q.sh[STAGES-2:0], rxd};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{sh: '1};
        else        q <= d;
    end

    assign line = q.sh[STAGES-1];
endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
    import serial_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line,
    input  logic              cfg_os16,
    input  logic              cfg_start_low,
    input  logic              cfg_lsb_first,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_two_stop,
    output logic              done_o,
    output logic [DATA_W-1:0] data_o,
    output logic              perr_o,
    output logic              ferr_o,
    output logic              brk_o
);
    localparam int BIT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] OS_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        rx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [BIT_W-1:0]  idx;
        logic [DATA_W-1:0] sh;
        logic              par;
        logic              all_lo;
        logic              stop2nd;
        logic              ferr;
        logic              done;
        logic              perr_p;
        logic              ferr_p;
        logic              brk_p;
    } frame_t;

    frame_t q, d;

    logic [CNT_W-1:0] os_last, half_last;
    logic             at_start, fe;

    always_comb begin
        os_last   = cfg_os16 ? OS_MAX : (OS_MAX >> 1);
        half_last = os_last >> 1;
        at_start  = (line == ~cfg_start_low);
        fe        = q.ferr | at_start;

        d        = q;
        d.done   = 1'b0;
        d.perr_p = 1'b0;
        d.ferr_p = 1'b0;
        d.brk_p  = 1'b0;

        if (tick) begin
            case (q.st)
                ST_IDLE: begin
                    if (at_start) begin
                        d.st  = ST_START;
                        d.cnt = '0;
                    end
                end
                ST_START: begin
                    if (q.cnt == half_last) begin
                        d.cnt = '0;
                        if (at_start) begin
                            d.st     = ST_DATA;
                            d.idx    = '0;
                            d.par    = 1'b0;
                            d.all_lo = 1'b1;
                            d.ferr   = 1'b0;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (q.cnt == os_last) begin
                        d.cnt    = '0;
                        d.par    = q.par ^ line;
                        d.all_lo = q.all_lo & at_start;
                        if (cfg_lsb_first) d.sh = {line, q.sh[DATA_W-1:1]};
                        else               d.sh = {q.sh[DATA_W-2:0], line};
                        if (q.idx == BIT_W'(DATA_W - 1)) begin
                            d.st      = cfg_par_en ? ST_PAR : ST_STOP;
                            d.stop2nd = 1'b0;
                        end else begin
                            d.idx = q.idx + 1'b1;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (q.cnt == os_last) begin
                        d.cnt    = '0;
                        d.par    = q.par ^ line;
                        d.all_lo = q.all_lo & at_start;
                        d.st     = ST_STOP;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (q.cnt == os_last) begin
                        d.cnt = '0;
                        if (cfg_two_stop && !q.stop2nd) begin
                            d.stop2nd = 1'b1;
                            d.ferr    = fe;
                            d.all_lo  = q.all_lo & at_start;
                        end else if (q.all_lo & at_start) begin
                            d.brk_p = 1'b1;
                            d.st    = ST_WAIT;
                        end else begin
                            d.done   = 1'b1;
                            d.ferr_p = fe;
                            d.perr_p = cfg_par_en & (q.par != cfg_par_odd);
                            d.st     = ST_IDLE;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (!at_start) d.st = ST_IDLE;
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done_o = q.done;
    assign data_o = q.sh;
    assign perr_o = q.perr_p;
    assign ferr_o = q.ferr_p;
    assign brk_o  = q.brk_p;

    // R2
    idle_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && !tick) |=> q.st == ST_IDLE);

    // R8
    brk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.brk_p |-> !q.done && !q.ferr_p && !q.perr_p);
endmodule

// File: rtl/serial_rx_hold.sv
module serial_rx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [DATA_W-1:0] data,
    input  logic              perr,
    input  logic              ferr,
    input  logic              brk,
    input  logic              rx_ready,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              err_parity,
    output logic              err_frame,
    output logic              err_break,
    output logic              err_overrun
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        logic              perr;
        logic              ferr;
        logic              brk;
        logic              ovr;
    } hold_t;

    hold_t q, d;

    always_comb begin
        d      = q;
        d.perr = 1'b0;
        d.ferr = 1'b0;
        d.brk  = brk;
        d.ovr  = 1'b0;
        if (q.valid && rx_ready) d.valid = 1'b0;
        if (done) begin
            if (q.valid && !rx_ready) begin
                d.ovr = 1'b1;
            end else begin
                d.valid = 1'b1;
                d.data  = data;
                d.perr  = perr;
                d.ferr  = ferr;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_valid    = q.valid;
    assign rx_data     = q.data;
    assign err_parity  = q.perr;
    assign err_frame   = q.ferr;
    assign err_break   = q.brk;
    assign err_overrun = q.ovr;

    // R10
    valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.valid && !rx_ready) |=> q.valid && $stable(q.data));

    // R9
    ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.ovr |-> q.valid);
endmodule

// File: rtl/serial_rx_irq.sv
module serial_rx_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic ie_global,
    input  logic ie_rx,
    input  logic ie_break,
    input  logic ie_parity,
    input  logic ie_frame,
    input  logic ie_overrun,
    input  logic rx_valid,
    input  logic err_break,
    input  logic err_parity,
    input  logic err_frame,
    input  logic err_overrun,
    output logic irq
);
    typedef struct packed {
        logic irq;
    } irq_t;

    irq_t q, d;

    always_comb begin
        d     = q;
        d.irq = ie_global & ((ie_rx & rx_valid) | (ie_break & err_break) |
                             (ie_parity & err_parity) | (ie_frame & err_frame) |
                             (ie_overrun & err_overrun));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign irq = q.irq;

    // R11
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ie_global |=> !q.irq);
endmodule

// File: rtl/serial_rx.sv
module serial_rx #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_tick,
    input  logic              rxd,
    input  logic              cfg_os16,
    input  logic              cfg_start_low,
    input  logic              cfg_lsb_first,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_two_stop,
    input  logic              cfg_rts_en,
    input  logic              ie_global,
    input  logic              ie_rx,
    input  logic              ie_break,
    input  logic              ie_parity,
    input  logic              ie_frame,
    input  logic              ie_overrun,
    input  logic              rx_ready,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              err_break,
    output logic              err_parity,
    output logic              err_frame,
    output logic              err_overrun,
    output logic              irq,
    output logic              rts_n,
    output logic              rts_oe
);
    logic              line;
    logic              fr_done, fr_perr, fr_ferr, fr_brk;
    logic [DATA_W-1:0] fr_data;

    serial_rx_sync #(.STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .line(line)
    );

    serial_rx_frame #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .tick(sample_tick), .line(line),
        .cfg_os16(cfg_os16), .cfg_start_low(cfg_start_low),
        .cfg_lsb_first(cfg_lsb_first), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop),
        .done_o(fr_done), .data_o(fr_data), .perr_o(fr_perr),
        .ferr_o(fr_ferr), .brk_o(fr_brk)
    );

    serial_rx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .done(fr_done), .data(fr_data),
        .perr(fr_perr), .ferr(fr_ferr), .brk(fr_brk), .rx_ready(rx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .err_parity(err_parity),
        .err_frame(err_frame), .err_break(err_break), .err_overrun(err_overrun)
    );

    serial_rx_irq u_irq (
        .clk(clk), .rst_n(rst_n), .ie_global(ie_global), .ie_rx(ie_rx),
        .ie_break(ie_break), .ie_parity(ie_parity), .ie_frame(ie_frame),
        .ie_overrun(ie_overrun), .rx_valid(rx_valid), .err_break(err_break),
        .err_parity(err_parity), .err_frame(err_frame),
        .err_overrun(err_overrun), .irq(irq)
    );

    assign rts_n  = rx_valid;
    assign rts_oe = cfg_rts_en;
endmodule

// File: tb/serial_rx_test.sv
module serial_rx_test;
    logic clk = 0;
    logic rst_n = 0;
    logic sample_tick = 0;
    logic rxd = 1;
    logic cfg_os16 = 1, cfg_start_low = 1, cfg_lsb_first = 0, cfg_par_en = 0;
    logic cfg_par_odd = 0, cfg_two_stop = 0, cfg_rts_en = 0;
    logic ie_global = 0, ie_rx = 0, ie_break = 0, ie_parity = 0, ie_frame = 0, ie_overrun = 0;
    logic rx_ready = 0;
    logic [7:0] rx_data;
    logic rx_valid, err_break, err_parity, err_frame, err_overrun, irq, rts_n, rts_oe;

    int errors = 0, checks = 0, tdiv = 1, tcnt = 0;
    int n_perr = 0, n_ferr = 0, n_brk = 0, n_ovr = 0, n_irq = 0;
    bit finished = 0;

    serial_rx uut (.*);

    always #5 clk = ~clk;

    initial begin
        forever begin
            @(negedge clk);
            if (tdiv <= 1) sample_tick = 1;
            else begin
                tcnt = (tcnt + 1) % tdiv;
                sample_tick = (tcnt == 0);
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            n_perr += int'(err_parity);
            n_ferr += int'(err_frame);
            n_brk  += int'(err_break);
            n_ovr  += int'(err_overrun);
            n_irq  += int'(irq);
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic st_lvl();
        return ~cfg_start_low;
    endfunction

    task automatic drive(logic v, int bits);
        rxd = v;
        repeat (bits * (cfg_os16 ? 16 : 8) * tdiv) @(negedge clk);
    endtask

    task automatic drive_frac(logic v, int ticks);
        rxd = v;
        repeat (ticks * tdiv) @(negedge clk);
    endtask

    task automatic send(logic [7:0] b, bit bad_par, bit bad_s1, bit bad_s2);
        logic p;
        drive(st_lvl(), 1);
        for (int i = 0; i < 8; i++) drive(cfg_lsb_first ? b[i] : b[7-i], 1);
        if (cfg_par_en) begin
            p = (^b) ^ cfg_par_odd ^ bad_par;
            drive(p, 1);
        end
        drive(bad_s1 ? st_lvl() : ~st_lvl(), 1);
        if (cfg_two_stop) drive(bad_s2 ? st_lvl() : ~st_lvl(), 1);
        drive(~st_lvl(), 2);
    endtask

    task automatic pop();
        rx_ready = 1;
        @(negedge clk);
        rx_ready = 0;
        @(negedge clk);
    endtask

    task automatic set_cfg(int c);
        cfg_os16      = c[0];
        cfg_start_low = c[1];
        cfg_lsb_first = c[2];
        cfg_par_en    = c[3];
        cfg_par_odd   = c[4];
        cfg_two_stop  = c[5];
        drive(~st_lvl(), 2);
    endtask

    // one frame with expected error counts
    task automatic frame_chk(string req, logic [7:0] b, bit bp, bit b1, bit b2,
                             int ep, int ef);
        int p0, f0, k0, o0;
        p0 = n_perr; f0 = n_ferr; k0 = n_brk; o0 = n_ovr;
        send(b, bp, b1, b2);
        chk(req, "valid", int'(rx_valid), 1);
        chk(req, "data", int'(rx_data), int'(b));
        chk(req, "parity pulses", n_perr - p0, ep);
        chk(req, "frame pulses", n_ferr - f0, ef);
        chk(req, "break/overrun pulses", (n_brk - k0) + (n_ovr - o0), 0);
        pop();
        chk("R10", "valid after read", int'(rx_valid), 0);
    endtask

    initial begin
        int k0, f0, p0, o0, i0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "valid", int'(rx_valid), 0);
        chk("R1", "irq", int'(irq), 0);
        chk("R1", "errors", int'(err_break | err_parity | err_frame | err_overrun), 0);
        chk("R1", "rts_n", int'(rts_n), 0);
        rst_n = 1;
        drive(1'b1, 2);

        // R2 R3 R4 R5 R6 sweep of all configurations
        for (int c = 0; c < 64; c++) begin
            set_cfg(c);
            for (int k = 0; k < 2; k++)
                frame_chk("R2/R3/R4 sweep", 8'(c * 53 + k * 149 + 17), 0, 0, 0, 0, 0);
        end

        // R5 parity errors, even then odd
        set_cfg(8 + 1 + 2);
        frame_chk("R5 even bad", 8'hA5, 1, 0, 0, 1, 0);
        set_cfg(16 + 8 + 1 + 2);
        frame_chk("R5 odd bad", 8'h3C, 1, 0, 0, 1, 0);

        // R6 framing errors
        set_cfg(1 + 2);
        frame_chk("R6 stop1 bad", 8'hA5, 0, 1, 0, 0, 1);
        set_cfg(32 + 1 + 2);
        frame_chk("R6 stop2 bad", 8'h5A, 0, 0, 1, 0, 1);

        // R7 false start
        set_cfg(1 + 2);
        k0 = n_brk + n_ferr + n_perr + n_ovr;
        drive_frac(st_lvl(), 4);
        drive(~st_lvl(), 3);
        chk("R7", "valid after glitch", int'(rx_valid), 0);
        chk("R7", "error pulses", n_brk + n_ferr + n_perr + n_ovr - k0, 0);
        set_cfg(2);
        drive_frac(st_lvl(), 2);
        drive(~st_lvl(), 3);
        chk("R7", "valid after glitch os8", int'(rx_valid), 0);

        // R8 break, inverted polarity, parity on
        set_cfg(8 + 1);
        k0 = n_brk; f0 = n_ferr; p0 = n_perr;
        drive(st_lvl(), 14);
        chk("R8", "break pulses", n_brk - k0, 1);
        drive(~st_lvl(), 2);
        chk("R8", "break pulses after release", n_brk - k0, 1);
        chk("R8", "frame pulses", n_ferr - f0, 0);
        chk("R8", "parity pulses", n_perr - p0, 0);
        chk("R8", "valid", int'(rx_valid), 0);
        frame_chk("R8 recovery", 8'h81, 0, 0, 0, 0, 0);

        // R9 overrun
        set_cfg(1 + 2 + 4);
        o0 = n_ovr;
        send(8'h11, 0, 0, 0);
        send(8'h22, 0, 0, 0);
        chk("R9", "overrun pulses", n_ovr - o0, 1);
        chk("R9", "kept data", int'(rx_data), 8'h11);
        chk("R10", "valid held", int'(rx_valid), 1);

        // R12 flow control
        cfg_rts_en = 0;
        @(negedge clk);
        chk("R12", "rts_oe off", int'(rts_oe), 0);
        cfg_rts_en = 1;
        @(negedge clk);
        chk("R12", "rts_oe on", int'(rts_oe), 1);
        chk("R12", "rts_n full", int'(rts_n), 1);

        // R11 byte interrupt gating
        ie_rx = 1; ie_global = 0;
        repeat (2) @(negedge clk);
        chk("R11", "irq global off", int'(irq), 0);
        ie_global = 1;
        repeat (2) @(negedge clk);
        chk("R11", "irq rx", int'(irq), 1);
        ie_rx = 0;
        repeat (2) @(negedge clk);
        chk("R11", "irq rx disabled", int'(irq), 0);
        pop();
        chk("R12", "rts_n empty", int'(rts_n), 0);

        // R11 error interrupt gating
        set_cfg(8 + 1 + 2);
        ie_parity = 1;
        i0 = n_irq;
        send(8'h0F, 1, 0, 0);
        pop();
        chk("R11", "parity irq cycles", n_irq - i0, 1);
        ie_parity = 0;
        i0 = n_irq;
        send(8'h0F, 1, 0, 0);
        pop();
        chk("R11", "parity irq masked", n_irq - i0, 0);
        ie_break = 1; ie_global = 0;
        i0 = n_irq;
        drive(st_lvl(), 13);
        drive(~st_lvl(), 2);
        chk("R11", "break irq global off", n_irq - i0, 0);
        ie_global = 1;
        i0 = n_irq;
        drive(st_lvl(), 13);
        drive(~st_lvl(), 2);
        chk("R11", "break irq", n_irq - i0, 1);
        ie_break = 0; ie_global = 0;

        // R2 slow strobe
        tdiv = 3;
        set_cfg(2 + 4);
        frame_chk("R2 strobe/3 os8", 8'hC6, 0, 0, 0, 0, 0);
        set_cfg(1 + 2 + 8 + 16);
        frame_chk("R2 strobe/3 os16", 8'h39, 0, 0, 0, 0, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1_900_000ns;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule